// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address through two memory lookups that depend on each other. The first lookup reads a directory entry and the second reads a table entry. The host loads a frame-aligned directory base register and then issues translation requests, one at a time. Each request carries a linear address and a paging-enable bit. The walker reads 32-bit entries from memory over a simple port: it holds a read request until a response arrives. It then reports either the physical address or a fault that names the level where the walk stopped.

The linear address is split at fixed bit positions. Bits 31..22 select one of 1024 directory entries. Bits 21..12 select one of 1024 entries in the page table that the directory entry points to. Bits 11..0 are the byte offset inside a 4 KiB page. Each entry is 4 bytes wide. Entry bit 0 marks the entry as present, and entry bits 31..12 give the frame of the next level, or of the final page. When paging is off, the walker does no memory reads and returns the address unchanged.

Top module: `page_walker`

## Requirements
- R1: After reset, reqReady is 1, doneValid and memRdValid are 0, donePhys is 0 and the directory base register holds 0.
- R2: When a request is accepted with pagingOn = 0, doneValid rises in the next cycle with donePhys equal to the request address and doneFault = 0, and no memory read is issued.
- R3: When paging is on, the first read goes to {base[31:12], lin[31:22], 2'b00}.
- R4: When the directory entry has bit 0 set, a second read goes to {pde[31:12], lin[21:12], 2'b00}.
- R5: When the table entry has bit 0 set, the walk finishes with doneFault = 0 and donePhys = {pte[31:12], lin[11:0]}.
- R6: A directory entry with bit 0 clear ends the walk with doneFault = 1 and faultLevel = 0, and no second read is issued.
- R7: A table entry with bit 0 clear ends the walk with doneFault = 1 and faultLevel = 1.
- R8: memRdValid stays high, with a steady memRdAddr, for any number of cycles until memRspValid is seen. The response is taken in the cycle in which it is present.
- R9: doneValid lasts exactly one cycle. reqReady is high only while idle and is low for the whole walk, so it never overlaps memRdValid or doneValid.
- R10: A write to the directory base register is accepted only while reqReady is high. A write made during a walk leaves the base unchanged for later walks.
- R11: reqValid raised while a walk is in progress is ignored and does not change that walk's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request, taken when reqReady is high |
| reqLinear | input | 32 | Linear address to translate |
| pagingOn | input | 1 | 1 walks the tables, 0 passes the address through |
| reqReady | output | 1 | Walker idle and able to take a request or a base write |
| baseWrEn | input | 1 | Load the directory base register |
| baseWrData | input | 32 | New directory base; bits 31..12 are kept |
| memRdValid | output | 1 | Memory read request, held until answered |
| memRdAddr | output | 32 | Byte address of the entry being read |
| memRspValid | input | 1 | Read data present |
| memRspData | input | 32 | Entry read from memory |
| doneValid | output | 1 | One-cycle completion pulse |
| donePhys | output | 32 | Physical address (valid when doneFault is 0) |
| doneFault | output | 1 | Walk ended on a non-present entry |
| faultLevel | output | 1 | 0 = directory entry, 1 = table entry |

## Verification
A controller stuck in a read state shows up at once as memRdValid staying high after a response, or as a missing doneValid. The bench's cycle limit per walk catches this. An index field taken from the wrong bits, or a frame taken from the wrong register, shows up on memRdAddr in the very cycle of the read. The bench compares it against its own address calculation before it answers. A present bit read from the wrong level, or a wrong level code, shows up at the single doneValid cycle as the wrong fault flag or the wrong level. A base register that takes writes while busy shows only on the next walk, which is why each busy-time write is followed by a checked walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // Page geometry; everything else is derived
  localparam int PAGE_BITS = 12;
  localparam int ENT_LOG2  = 2;
  localparam int IDX_W     = PAGE_BITS - ENT_LOG2;
  localparam int ADDR_W    = PAGE_BITS + 2 * IDX_W;
  localparam int FRAME_W   = ADDR_W - PAGE_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_DIR,
    ST_READ_TBL,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic baseLoad;   // take host base write
    logic linLoad;    // capture linear address
    logic passLoad;   // result = linear (paging off)
    logic dirTake;    // capture directory entry frame
    logic tblTake;    // capture final physical address
    logic useTable;   // address mux selects table stage
  } pwStrobe_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       pagingOn,
  input  logic       baseWrEn,
  input  logic       memRspValid,
  input  logic       rspPresent,
  output pwStrobe_t  strb,
  output logic       reqReady,
  output logic       memRdValid,
  output logic       doneValid,
  output logic       doneFault,
  output logic       faultLevel
);
  walkState_t state, stateNxt;
  logic       faultLvlReg, faultLvlNxt;
  logic       accept;

  assign accept = (state == ST_IDLE) && reqValid;

  always_comb begin
    stateNxt    = state;
    faultLvlNxt = faultLvlReg;
    unique case (state)
      ST_IDLE: begin
        if (accept) stateNxt = pagingOn ? ST_READ_DIR : ST_DONE;
      end
      ST_READ_DIR: begin
        if (memRspValid) begin
          if (rspPresent) stateNxt = ST_READ_TBL;
          else begin
            stateNxt    = ST_FAULT;
            faultLvlNxt = 1'b0;
          end
        end
      end
      ST_READ_TBL: begin
        if (memRspValid) begin
          if (rspPresent) stateNxt = ST_DONE;
          else begin
            stateNxt    = ST_FAULT;
            faultLvlNxt = 1'b1;
          end
        end
      end
      ST_DONE:  stateNxt = ST_IDLE;
      ST_FAULT: stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      faultLvlReg <= 1'b0;
    end else begin
      state       <= stateNxt;
      faultLvlReg <= faultLvlNxt;
    end
  end

  always_comb begin
    strb          = '0;
    strb.baseLoad = (state == ST_IDLE) && baseWrEn;
    strb.linLoad  = accept;
    strb.passLoad = accept && !pagingOn;
    strb.dirTake  = (state == ST_READ_DIR) && memRspValid && rspPresent;
    strb.tblTake  = (state == ST_READ_TBL) && memRspValid && rspPresent;
    strb.useTable = (state == ST_READ_TBL);
  end

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = (state == ST_READ_DIR) || (state == ST_READ_TBL);
  assign doneValid  = (state == ST_DONE) || (state == ST_FAULT);
  assign doneFault  = (state == ST_FAULT);
  assign faultLevel = faultLvlReg;
endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqLinear,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspPresent,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] donePhys
);
  logic [FRAME_W-1:0] baseFrame;
  logic [FRAME_W-1:0] tblFrame;
  logic [ADDR_W-1:0]  linReg;
  logic [ADDR_W-1:0]  physReg;
  logic [IDX_W-1:0]   dirIdx, tblIdx;
  logic [FRAME_W-1:0] rspFrame;

  assign dirIdx     = linReg[ADDR_W-1 -: IDX_W];
  assign tblIdx     = linReg[PAGE_BITS +: IDX_W];
  assign rspFrame   = memRspData[ADDR_W-1 -: FRAME_W];
  assign rspPresent = memRspData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseFrame <= '0;
      tblFrame  <= '0;
      linReg    <= '0;
      physReg   <= '0;
    end else begin
      if (strb.baseLoad) baseFrame <= baseWrData[ADDR_W-1 -: FRAME_W];
      if (strb.linLoad)  linReg    <= reqLinear;
      if (strb.dirTake)  tblFrame  <= rspFrame;
      if (strb.passLoad) physReg   <= reqLinear;
      else if (strb.tblTake)
        physReg <= {rspFrame, linReg[PAGE_BITS-1:0]};
    end
  end

  always_comb begin
    if (strb.useTable) memRdAddr = {tblFrame, tblIdx, {ENT_LOG2{1'b0}}};
    else               memRdAddr = {baseFrame, dirIdx, {ENT_LOG2{1'b0}}};
  end

  assign donePhys = physReg;
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqLinear,
  input  logic              pagingOn,
  output logic              reqReady,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  output logic              memRdValid,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePhys,
  output logic              doneFault,
  output logic              faultLevel
);
  pwStrobe_t strb;
  logic      rspPresent;

  pw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .pagingOn   (pagingOn),
    .baseWrEn   (baseWrEn),
    .memRspValid(memRspValid),
    .rspPresent (rspPresent),
    .strb       (strb),
    .reqReady   (reqReady),
    .memRdValid (memRdValid),
    .doneValid  (doneValid),
    .doneFault  (doneFault),
    .faultLevel (faultLevel)
  );

  pw_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqLinear (reqLinear),
    .baseWrData(baseWrData),
    .memRspData(memRspData),
    .rspPresent(rspPresent),
    .memRdAddr (memRdAddr),
    .donePhys  (donePhys)
  );
endmodule

// File: rtl/pw_checker.sv
module pw_checker
  import pw_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqLinear,
  input logic               pagingOn,
  input logic               reqReady,
  input logic               memRdValid,
  input logic [ADDR_W-1:0]  memRdAddr,
  input logic               memRspValid,
  input logic [ADDR_W-1:0]  memRspData,
  input logic               doneValid,
  input logic [ADDR_W-1:0]  donePhys,
  input logic               doneFault,
  input logic [FRAME_W-1:0] baseFrame
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R9

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memRdValid && !doneValid)); // R9

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRspValid) |=> (memRdValid && $stable(memRdAddr))); // R8

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid && !pagingOn) |=>
      (doneValid && !doneFault && !memRdValid && donePhys == $past(reqLinear))); // R2

  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && memRspValid && !memRspData[0]) |=> (doneValid && doneFault)); // R6

  AST_PRESENT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && memRspValid && memRspData[0]) |=>
      (memRdValid || (doneValid && !doneFault))); // R5

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |=> $stable(baseFrame)); // R10
endmodule

bind page_walker pw_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqLinear  (reqLinear),
  .pagingOn   (pagingOn),
  .reqReady   (reqReady),
  .memRdValid (memRdValid),
  .memRdAddr  (memRdAddr),
  .memRspValid(memRspValid),
  .memRspData (memRspData),
  .doneValid  (doneValid),
  .donePhys   (donePhys),
  .doneFault  (doneFault),
  .baseFrame  (u_dp.baseFrame)
);

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, pagingOn, baseWrEn, memRspValid;
  logic [31:0] reqLinear, baseWrData, memRspData;
  logic        reqReady, memRdValid, doneValid, doneFault, faultLevel;
  logic [31:0] memRdAddr, donePhys;

  int checks = 0;
  int errors = 0;
  logic [31:0] baseM = 32'h0;
  logic [31:0] salt = 32'h1234_5678;
  logic        killOn = 1'b0;
  logic [31:0] killAddr = 32'h0;
  int unsigned seedV = 32'd7;

  always #4 clk = ~clk;

  page_walker dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    logic [31:0] h;
    h = (a ^ salt) * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    if (killOn && a == killAddr) h[0] = 1'b0;
    else h[0] = (h[6:4] != 3'd0);
    return h;
  endfunction

  task automatic setBase(input logic [31:0] v);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = v;
    @(negedge clk);
    baseWrEn = 1'b0;
    baseM = {v[31:12], 12'h0};
  endtask

  task automatic doWalk(input logic [31:0] lin, input logic pg, input int lat,
                        input int killSel, input bit noise);
    logic [31:0] pdeA, pde, pteA, pte, expPhys, expA;
    logic expFault, expLvl;
    int expReads, reads, waitCnt, cyc;
    bit first;
    pdeA = {baseM[31:12], lin[31:22], 2'b00};
    killOn = (killSel != 0);
    if (killSel == 1) killAddr = pdeA;
    pde  = memWord(pdeA);
    pteA = {pde[31:12], lin[21:12], 2'b00};
    if (killSel == 2) killAddr = pteA;
    pte  = memWord(pteA);
    expFault = 1'b0; expLvl = 1'b0; expPhys = 32'h0;
    if (!pg) begin expReads = 0; expPhys = lin; end
    else if (!pde[0]) begin expReads = 1; expFault = 1'b1; expLvl = 1'b0; end
    else if (!pte[0]) begin expReads = 2; expFault = 1'b1; expLvl = 1'b1; end
    else begin expReads = 2; expPhys = {pte[31:12], lin[11:0]}; end

    @(negedge clk);
    chk(reqReady, "R9 ready before request", {31'h0, reqReady}, 32'h1);
    reqValid = 1'b1; reqLinear = lin; pagingOn = pg;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R9 busy after accept", {31'h0, reqReady}, 32'h0);
    reads = 0; waitCnt = 0; cyc = 0; first = 1'b1;
    while (!doneValid && cyc < 100) begin
      if (noise && first) begin
        baseWrEn = 1'b1; baseWrData = ~baseM;
        reqValid = 1'b1; reqLinear = ~lin;
      end
      if (memRdValid) begin
        expA = (reads == 0) ? pdeA : pteA;
        if (reads == 0) chk(memRdAddr == expA, "R3 directory address", memRdAddr, expA);
        else            chk(memRdAddr == expA, "R4 table address", memRdAddr, expA);
        if (waitCnt > 0) chk(memRdValid, "R8 request held", {31'h0, memRdValid}, 32'h1);
        if (waitCnt >= lat) begin
          memRspValid = 1'b1; memRspData = memWord(memRdAddr);
          reads++; waitCnt = 0;
        end else waitCnt++;
      end
      @(negedge clk);
      memRspValid = 1'b0; baseWrEn = 1'b0; reqValid = 1'b0; first = 1'b0;
      cyc++;
    end
    if (!doneValid) chk(1'b0, "R9 walk finished", 32'h0, 32'h1);
    else begin
      chk(reads == expReads, "R6 read count", reads, expReads);
      chk(doneFault == expFault, expFault ? "R7 fault flag" : "R5 fault flag",
          {31'h0, doneFault}, {31'h0, expFault});
      if (expFault)
        chk(faultLevel == expLvl, expLvl ? "R7 level" : "R6 level",
            {31'h0, faultLevel}, {31'h0, expLvl});
      else if (!pg)
        chk(donePhys == expPhys, "R2 pass-through", donePhys, expPhys);
      else
        chk(donePhys == expPhys, noise ? "R11 result kept" : "R5 physical",
            donePhys, expPhys);
      @(negedge clk);
      chk(!doneValid && reqReady, "R9 pulse width",
          {30'h0, doneValid, reqReady}, 32'h1);
    end
    killOn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rstN = 1'b0; reqValid = 1'b0; pagingOn = 1'b0; baseWrEn = 1'b0;
    memRspValid = 1'b0; reqLinear = '0; baseWrData = '0; memRspData = '0;
    r = $urandom(seedV);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !doneValid && !memRdValid, "R1 idle outputs",
        {29'h0, reqReady, doneValid, memRdValid}, 32'h4);
    chk(donePhys == 32'h0, "R1 result cleared", donePhys, 32'h0);
    // R1: base is zero, so a walk with base untouched reads from frame 0
    doWalk(32'h0040_3ABC, 1'b1, 0, 0, 1'b0);
    // R2 pass-through
    doWalk(32'hDEAD_BEEF, 1'b0, 0, 0, 1'b0);
    setBase(32'h0012_3FFF);
    doWalk(32'h8765_4321, 1'b1, 0, 0, 1'b0);
    doWalk(32'h0000_0000, 1'b1, 3, 0, 1'b0);          // R8 latency
    doWalk(32'hFFFF_FFFF, 1'b1, 2, 0, 1'b0);
    doWalk(32'h1357_9BDF, 1'b1, 1, 1, 1'b0);          // R6 directory fault
    doWalk(32'h2468_ACE0, 1'b1, 2, 2, 1'b0);          // R7 table fault
    doWalk(32'h0ABC_D123, 1'b1, 3, 0, 1'b1);          // R10, R11 busy noise
    doWalk(32'h0ABC_D124, 1'b1, 0, 0, 1'b0);          // R10 base unchanged
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 10 == 0) setBase($urandom);
      if ($urandom % 16 == 0) salt = $urandom;
      doWalk($urandom, ($urandom % 8) != 0, $urandom % 4,
             (($urandom % 6) < 2) ? int'($urandom % 3) : 0, ($urandom % 12) == 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule